// File: doc/BRIEF.md
# USB OUT/SETUP Handshake Decision Controller

This block chooses how a full-speed USB device answers each SETUP or OUT transaction. It takes three things: the decoded token (PID, address, endpoint), the verdict on the data packet that follows (PID and CRC result), and the fill state of the buffer FIFOs. From these it produces one of four answers: ACK, NAK, STALL, or silence. When a packet is to be kept, it raises a commit strobe for the receive FIFO. It also owns the endpoint state bits that it must change on its own: the expected data toggle, the OUT and IN stall flags, and the per-endpoint OUT receive enable. Software can write each of these bits one at a time.

The rules are layered with a fixed priority:

1. A bad CRC, or a data PID that is neither DATA0 nor DATA1, silences everything.
2. SETUP has its own path. It ignores stall and reserves the last receive-FIFO slot for itself.
3. For OUT, the order is: stall, then receive disabled, then no free buffer or reserved slot, then toggle mismatch, then accept.
4. An isochronous endpoint never sends a handshake.

A three-state machine sequences each transaction:

- ST_IDLE waits for a token. A matching OUT or SETUP token moves it to ST_WAIT_DATA. Any other token leaves it in ST_IDLE.
- ST_WAIT_DATA moves to ST_RESPOND on the data packet. A further matching token restarts the wait. Any other token drops back to ST_IDLE.
- ST_RESPOND drives the result for one cycle, then returns to ST_IDLE, or to ST_WAIT_DATA if a matching token arrives in that same cycle.

Top module: `usb_out_hs_ctrl`

## Requirements
- R1: After reset, all toggle, OUT-stall, IN-stall and receive-enable bits are 0, and `hs_valid_o`, `rx_commit_o` and `link_err_o` are low.
- R2: A token is ignored, with no handshake, no commit and no state change, in any of these cases: its address differs from `dev_addr_i`, its endpoint is NEP or above, its endpoint's `ep_out_en_i` bit is 0, or its PID is neither OUT (4'b0001) nor SETUP (4'b1101). A data packet with no preceding matching token is also ignored.
- R3: An OUT to an endpoint whose OUT-stall bit is set is answered with STALL (PID 4'b1110), whatever its receive-enable and buffer state. Stall outranks NAK.
- R4: An OUT to a non-stalled endpoint whose receive-enable bit is 0 is answered with NAK (PID 4'b1010), and nothing is committed.
- R5: With receive enabled, an OUT is NAKed if `av_out_empty_i` is high or `rx_level_i` is at least RX_DEPTH-1, since the last slot is reserved for SETUP. A SETUP is still accepted at level RX_DEPTH-1.
- R6: An accepted OUT on a non-iso endpoint whose data PID toggle (PID bit 3: DATA0=4'b0011, DATA1=4'b1011) matches the stored toggle does three things. It is answered with ACK (PID 4'b0010). It pulses `rx_commit_o` with the endpoint on `rx_commit_ep_o` and `rx_commit_setup_o` low. It flips the stored toggle. If the endpoint's `set_nak_out_i` bit is 1, the receive-enable bit is also cleared.
- R7: An OUT that passes R3 to R5 but carries the wrong toggle is answered with ACK and pulses `link_err_o`. It commits nothing and leaves the toggle and receive-enable bits unchanged.
- R8: An OUT on an endpoint with its `out_iso_i` bit set never produces a handshake. When R3 to R5 do not refuse it, it is committed whatever its toggle, the toggle is left unchanged, and the set-NAK rule of R6 applies.
- R9: A SETUP is accepted only if three conditions hold: `rx_setup_en_i` is set for the endpoint, `av_setup_empty_i` is low, and `rx_level_i` is below RX_DEPTH. An accepted SETUP gets ACK, pulses `rx_commit_o` with `rx_commit_setup_o` high, clears both stall bits of the endpoint and sets its toggle to 1. Any other SETUP gets no response and changes nothing.
- R10: A data packet with `dat_crc_ok_i` low, or with a PID that is neither DATA0 nor DATA1, gets no handshake, no commit, no link error and no state change.
- R11: A software write selects a field with `sw_field_i` (0 toggle, 1 OUT stall, 2 IN stall, 3 receive enable) and an endpoint with `sw_ep_i`, and sets that bit to `sw_val_i` at the next edge. Writing 0 to a toggle makes the next accepted OUT expect DATA0, and that OUT then flips the toggle to 1.
- R12: The handshake, commit and link-error outputs are high only in the cycle after the edge that samples `dat_valid_i`. The state bits take their new values at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dev_addr_i | input | 7 | Programmed device address |
| ep_out_en_i | input | NEP | Per-endpoint OUT/SETUP enable |
| rx_setup_en_i | input | NEP | Per-endpoint SETUP reception enable |
| out_iso_i | input | NEP | Per-endpoint isochronous OUT mode |
| set_nak_out_i | input | NEP | Clear receive enable after each accepted OUT |
| sw_we_i | input | 1 | Software bit write strobe |
| sw_field_i | input | 2 | Field select for the software write |
| sw_ep_i | input | EPW | Endpoint for the software write |
| sw_val_i | input | 1 | Value written |
| tok_valid_i | input | 1 | Token strobe |
| tok_pid_i | input | 4 | Token PID |
| tok_addr_i | input | 7 | Token address |
| tok_ep_i | input | EPW | Token endpoint |
| dat_valid_i | input | 1 | Data packet end strobe |
| dat_pid_i | input | 4 | Data packet PID |
| dat_crc_ok_i | input | 1 | Data CRC16 passed |
| av_out_empty_i | input | 1 | Available OUT buffer FIFO empty |
| av_setup_empty_i | input | 1 | Available SETUP buffer FIFO empty |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| hs_valid_o | output | 1 | Handshake to be sent |
| hs_pid_o | output | 4 | Handshake PID (0 when none) |
| rx_commit_o | output | 1 | Commit packet to the receive FIFO |
| rx_commit_setup_o | output | 1 | Committed packet is a SETUP |
| rx_commit_ep_o | output | EPW | Endpoint of the committed packet |
| link_err_o | output | 1 | Toggle-mismatch link error pulse |
| toggle_o | output | NEP | Expected OUT data toggle per endpoint |
| out_stall_o | output | NEP | OUT stall bits |
| in_stall_o | output | NEP | IN stall bits |
| rx_out_en_o | output | NEP | OUT receive-enable bits |

## Verification
A token sampled at one edge and its data packet sampled at the next produce the handshake, commit and link-error outputs in the cycle after the data edge. The endpoint state bits follow one edge later. The bench therefore drives on falling edges and samples the response on the falling edge after the data edge. It reads the state bits one falling edge later. A software write is visible one falling edge after it is driven. The bench also confirms that the outputs are still low in the cycle before the response, and low again in the cycle after it. Sweeps over every combination of stall, enable, buffer, level, iso, set-NAK and toggle match are compared with a priority model computed in the bench.

// File: rtl/usb_out_hs_pkg.sv
package usb_out_hs_pkg;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;
    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;

    localparam logic [1:0] FLD_TOGGLE = 2'd0;
    localparam logic [1:0] FLD_OSTALL = 2'd1;
    localparam logic [1:0] FLD_ISTALL = 2'd2;
    localparam logic [1:0] FLD_RXEN   = 2'd3;

    typedef enum logic [1:0] {
        HS_NONE,
        HS_ACK,
        HS_NAK,
        HS_STALL
    } hs_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DATA,
        ST_RESPOND
    } fsm_state_e;

    typedef struct packed {
        hs_kind_e hs;
        logic     commit;
        logic     link_err;
        logic     tog_flip;
        logic     tog_set1;
        logic     clr_stall;
        logic     clr_rxen;
    } decision_t;

    function automatic logic [3:0] hs_to_pid(hs_kind_e k);
        logic [3:0] p;
        unique case (k)
            HS_ACK:   p = PID_ACK;
            HS_NAK:   p = PID_NAK;
            HS_STALL: p = PID_STALL;
            default:  p = 4'b0000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/usb_out_hs_policy.sv
module usb_out_hs_policy
    import usb_out_hs_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int LVL_W    = 3
) (
    input  logic             is_setup_i,
    input  logic [3:0]       dat_pid_i,
    input  logic             crc_ok_i,
    input  logic             out_stall_i,
    input  logic             rx_out_en_i,
    input  logic             rx_setup_en_i,
    input  logic             iso_i,
    input  logic             set_nak_i,
    input  logic             toggle_i,
    input  logic             av_out_empty_i,
    input  logic             av_setup_empty_i,
    input  logic [LVL_W-1:0] rx_level_i,
    output decision_t        dec_o
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(RX_DEPTH);
    localparam logic [LVL_W-1:0] RESV_LVL = LVL_W'(RX_DEPTH - 1);

    logic pid_ok;
    logic rx_full;
    logic rx_resv;
    logic tog_match;

    always_comb begin
        pid_ok    = (dat_pid_i == PID_DATA0) || (dat_pid_i == PID_DATA1);
        rx_full   = rx_level_i >= FULL_LVL;
        rx_resv   = rx_level_i >= RESV_LVL;
        tog_match = dat_pid_i[3] == toggle_i;
    end

    always_comb begin
        dec_o    = '0;
        dec_o.hs = HS_NONE;
        if (!crc_ok_i || !pid_ok) begin
            dec_o.hs = HS_NONE;
        end else if (is_setup_i) begin
            if (rx_setup_en_i && !av_setup_empty_i && !rx_full) begin
                dec_o.hs        = HS_ACK;
                dec_o.commit    = 1'b1;
                dec_o.clr_stall = 1'b1;
                dec_o.tog_set1  = 1'b1;
            end
        end else if (out_stall_i) begin
            dec_o.hs = iso_i ? HS_NONE : HS_STALL;
        end else if (!rx_out_en_i || av_out_empty_i || rx_resv) begin
            dec_o.hs = iso_i ? HS_NONE : HS_NAK;
        end else if (iso_i) begin
            dec_o.commit   = 1'b1;
            dec_o.clr_rxen = set_nak_i;
        end else if (!tog_match) begin
            dec_o.hs       = HS_ACK;
            dec_o.link_err = 1'b1;
        end else begin
            dec_o.hs       = HS_ACK;
            dec_o.commit   = 1'b1;
            dec_o.tog_flip = 1'b1;
            dec_o.clr_rxen = set_nak_i;
        end
    end

    always_comb begin
        if (crc_ok_i && iso_i && !is_setup_i) begin
            assert_iso_quiet_R8: assert (dec_o.hs == HS_NONE);
        end
        if (!crc_ok_i) begin
            assert_crc_drop_R10: assert (!dec_o.commit && !dec_o.link_err);
        end
    end

endmodule

// File: rtl/usb_out_hs_epbank.sv
module usb_out_hs_epbank
    import usb_out_hs_pkg::*;
#(
    parameter int NEP = 12,
    parameter int EPW = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           sw_we_i,
    input  logic [1:0]     sw_field_i,
    input  logic [EPW-1:0] sw_ep_i,
    input  logic           sw_val_i,
    input  logic           upd_i,
    input  logic [EPW-1:0] upd_ep_i,
    input  logic           tog_flip_i,
    input  logic           tog_set1_i,
    input  logic           clr_stall_i,
    input  logic           clr_rxen_i,
    output logic [NEP-1:0] toggle_o,
    output logic [NEP-1:0] out_stall_o,
    output logic [NEP-1:0] in_stall_o,
    output logic [NEP-1:0] rx_out_en_o
);

    for (genvar e = 0; e < NEP; e++) begin : g_ep
        logic tog_q, ost_q, ist_q, rxen_q;
        logic sw_hit, hw_hit;

        always_comb begin
            sw_hit = sw_we_i && (sw_ep_i == EPW'(e));
            hw_hit = upd_i && (upd_ep_i == EPW'(e));
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                tog_q  <= 1'b0;
                ost_q  <= 1'b0;
                ist_q  <= 1'b0;
                rxen_q <= 1'b0;
            end else begin
                if (sw_hit) begin
                    unique case (sw_field_i)
                        FLD_TOGGLE: tog_q  <= sw_val_i;
                        FLD_OSTALL: ost_q  <= sw_val_i;
                        FLD_ISTALL: ist_q  <= sw_val_i;
                        default:    rxen_q <= sw_val_i;
                    endcase
                end
                if (hw_hit) begin
                    if (tog_flip_i) tog_q <= ~tog_q;
                    if (tog_set1_i) tog_q <= 1'b1;
                    if (clr_stall_i) begin
                        ost_q <= 1'b0;
                        ist_q <= 1'b0;
                    end
                    if (clr_rxen_i) rxen_q <= 1'b0;
                end
            end
        end

        assign toggle_o[e]    = tog_q;
        assign out_stall_o[e] = ost_q;
        assign in_stall_o[e]  = ist_q;
        assign rx_out_en_o[e] = rxen_q;

        // R9: an accepted SETUP leaves both stall bits clear
        assert_setup_unstall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hw_hit && clr_stall_i) |=> (!ost_q && !ist_q));

        // R6: an accepted in-sequence OUT inverts the expected toggle
        assert_toggle_flips_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hw_hit && tog_flip_i) |=> (tog_q != $past(tog_q)));
    end

endmodule

// File: rtl/usb_out_hs_ctrl.sv
module usb_out_hs_ctrl
    import usb_out_hs_pkg::*;
#(
    parameter  int NEP      = 12,
    parameter  int RX_DEPTH = 4,
    localparam int EPW      = (NEP > 1) ? $clog2(NEP) : 1,
    localparam int LVL_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [6:0]       dev_addr_i,
    input  logic [NEP-1:0]   ep_out_en_i,
    input  logic [NEP-1:0]   rx_setup_en_i,
    input  logic [NEP-1:0]   out_iso_i,
    input  logic [NEP-1:0]   set_nak_out_i,
    input  logic             sw_we_i,
    input  logic [1:0]       sw_field_i,
    input  logic [EPW-1:0]   sw_ep_i,
    input  logic             sw_val_i,
    input  logic             tok_valid_i,
    input  logic [3:0]       tok_pid_i,
    input  logic [6:0]       tok_addr_i,
    input  logic [EPW-1:0]   tok_ep_i,
    input  logic             dat_valid_i,
    input  logic [3:0]       dat_pid_i,
    input  logic             dat_crc_ok_i,
    input  logic             av_out_empty_i,
    input  logic             av_setup_empty_i,
    input  logic [LVL_W-1:0] rx_level_i,
    output logic             hs_valid_o,
    output logic [3:0]       hs_pid_o,
    output logic             rx_commit_o,
    output logic             rx_commit_setup_o,
    output logic [EPW-1:0]   rx_commit_ep_o,
    output logic             link_err_o,
    output logic [NEP-1:0]   toggle_o,
    output logic [NEP-1:0]   out_stall_o,
    output logic [NEP-1:0]   in_stall_o,
    output logic [NEP-1:0]   rx_out_en_o
);

    localparam int EPN = 2 ** EPW;

    fsm_state_e     state_q, state_d;
    logic [EPW-1:0] cur_ep_q;
    logic           cur_setup_q;
    decision_t      dec_q, dec_w;
    logic           load_tok, load_dec;
    logic           tok_hit;

    logic [EPN-1:0] en_pad, rse_pad, iso_pad, snak_pad;
    logic [EPN-1:0] tog_pad, ost_pad, rxen_pad;

    always_comb begin
        en_pad   = EPN'(ep_out_en_i);
        rse_pad  = EPN'(rx_setup_en_i);
        iso_pad  = EPN'(out_iso_i);
        snak_pad = EPN'(set_nak_out_i);
        tog_pad  = EPN'(toggle_o);
        ost_pad  = EPN'(out_stall_o);
        rxen_pad = EPN'(rx_out_en_o);
        tok_hit  = tok_valid_i
                 && ((tok_pid_i == PID_OUT) || (tok_pid_i == PID_SETUP))
                 && (tok_addr_i == dev_addr_i)
                 && en_pad[tok_ep_i];
    end

    usb_out_hs_policy #(
        .RX_DEPTH(RX_DEPTH),
        .LVL_W   (LVL_W)
    ) u_policy (
        .is_setup_i      (cur_setup_q),
        .dat_pid_i       (dat_pid_i),
        .crc_ok_i        (dat_crc_ok_i),
        .out_stall_i     (ost_pad[cur_ep_q]),
        .rx_out_en_i     (rxen_pad[cur_ep_q]),
        .rx_setup_en_i   (rse_pad[cur_ep_q]),
        .iso_i           (iso_pad[cur_ep_q]),
        .set_nak_i       (snak_pad[cur_ep_q]),
        .toggle_i        (tog_pad[cur_ep_q]),
        .av_out_empty_i  (av_out_empty_i),
        .av_setup_empty_i(av_setup_empty_i),
        .rx_level_i      (rx_level_i),
        .dec_o           (dec_w)
    );

    usb_out_hs_epbank #(
        .NEP(NEP),
        .EPW(EPW)
    ) u_epbank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_we_i    (sw_we_i),
        .sw_field_i (sw_field_i),
        .sw_ep_i    (sw_ep_i),
        .sw_val_i   (sw_val_i),
        .upd_i      (state_q == ST_RESPOND),
        .upd_ep_i   (cur_ep_q),
        .tog_flip_i (dec_q.tog_flip),
        .tog_set1_i (dec_q.tog_set1),
        .clr_stall_i(dec_q.clr_stall),
        .clr_rxen_i (dec_q.clr_rxen),
        .toggle_o   (toggle_o),
        .out_stall_o(out_stall_o),
        .in_stall_o (in_stall_o),
        .rx_out_en_o(rx_out_en_o)
    );

    always_comb begin
        state_d  = state_q;
        load_tok = 1'b0;
        load_dec = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_hit) begin
                    state_d  = ST_WAIT_DATA;
                    load_tok = 1'b1;
                end
            end
            ST_WAIT_DATA: begin
                if (dat_valid_i) begin
                    state_d  = ST_RESPOND;
                    load_dec = 1'b1;
                end else if (tok_hit) begin
                    load_tok = 1'b1;
                end else if (tok_valid_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RESPOND: begin
                if (tok_hit) begin
                    state_d  = ST_WAIT_DATA;
                    load_tok = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            cur_ep_q    <= '0;
            cur_setup_q <= 1'b0;
            dec_q       <= '0;
        end else begin
            state_q <= state_d;
            if (load_tok) begin
                cur_ep_q    <= tok_ep_i;
                cur_setup_q <= tok_pid_i == PID_SETUP;
            end
            if (load_dec) dec_q <= dec_w;
        end
    end

    always_comb begin
        hs_valid_o        = 1'b0;
        hs_pid_o          = 4'b0000;
        rx_commit_o       = 1'b0;
        rx_commit_setup_o = 1'b0;
        rx_commit_ep_o    = '0;
        link_err_o        = 1'b0;
        unique case (state_q)
            ST_RESPOND: begin
                hs_valid_o        = dec_q.hs != HS_NONE;
                hs_pid_o          = hs_to_pid(dec_q.hs);
                rx_commit_o       = dec_q.commit;
                rx_commit_setup_o = dec_q.commit && cur_setup_q;
                rx_commit_ep_o    = dec_q.commit ? cur_ep_q : '0;
                link_err_o        = dec_q.link_err;
            end
            default: begin
                hs_valid_o = 1'b0;
            end
        endcase
    end

    // R12: a response only follows a sampled data packet
    assert_resp_after_data_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_valid_o || rx_commit_o || link_err_o) |-> $past(dat_valid_i));

    // R6: nothing is committed while refusing with NAK or STALL
    assert_commit_not_refused_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_commit_o |-> (hs_pid_o != PID_NAK && hs_pid_o != PID_STALL));

    // R7: a toggle error never commits
    assert_err_no_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_err_o |-> (!rx_commit_o && hs_pid_o == PID_ACK));

    // R8: isochronous OUT endpoints stay silent
    assert_iso_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RESPOND && !cur_setup_q && iso_pad[cur_ep_q]) |-> !hs_valid_o);

    // R3: a stall answer is only given to a stalled endpoint
    assert_stall_only_stalled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_pid_o == PID_STALL) |-> ost_pad[cur_ep_q]);

endmodule

// File: tb/usb_out_hs_ctrl_test.sv
module usb_out_hs_ctrl_test;
    import usb_out_hs_pkg::*;

    localparam int NEP   = 12;
    localparam int RXD   = 4;
    localparam int EPW   = 4;
    localparam int LVL_W = 3;
    localparam logic [6:0] ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [6:0]       dev_addr = ADDR;
    logic [NEP-1:0]   ep_en = '1, rse_v = '1, iso_v = '0, snak_v = '0;
    logic             sw_we = 1'b0, sw_val = 1'b0;
    logic [1:0]       sw_field = '0;
    logic [EPW-1:0]   sw_ep = '0;
    logic             tok_valid = 1'b0, dat_valid = 1'b0, crc_ok = 1'b1;
    logic [3:0]       tok_pid = '0, dat_pid = '0;
    logic [6:0]       tok_addr = '0;
    logic [EPW-1:0]   tok_ep = '0;
    logic             av_out_empty = 1'b0, av_setup_empty = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;

    logic             hs_valid, rx_commit, rx_commit_setup, link_err;
    logic [3:0]       hs_pid;
    logic [EPW-1:0]   rx_commit_ep;
    logic [NEP-1:0]   toggle, out_stall, in_stall, rx_out_en;

    usb_out_hs_ctrl #(.NEP(NEP), .RX_DEPTH(RXD)) uut (
        .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr),
        .ep_out_en_i(ep_en), .rx_setup_en_i(rse_v), .out_iso_i(iso_v),
        .set_nak_out_i(snak_v), .sw_we_i(sw_we), .sw_field_i(sw_field),
        .sw_ep_i(sw_ep), .sw_val_i(sw_val), .tok_valid_i(tok_valid),
        .tok_pid_i(tok_pid), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep),
        .dat_valid_i(dat_valid), .dat_pid_i(dat_pid), .dat_crc_ok_i(crc_ok),
        .av_out_empty_i(av_out_empty), .av_setup_empty_i(av_setup_empty),
        .rx_level_i(rx_level), .hs_valid_o(hs_valid), .hs_pid_o(hs_pid),
        .rx_commit_o(rx_commit), .rx_commit_setup_o(rx_commit_setup),
        .rx_commit_ep_o(rx_commit_ep), .link_err_o(link_err),
        .toggle_o(toggle), .out_stall_o(out_stall), .in_stall_o(in_stall),
        .rx_out_en_o(rx_out_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    int r_pid, r_commit, r_setup, r_ep, r_err, r_pre, r_post;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sw_wr(input logic [1:0] f, input int ep, input int v);
        @(negedge clk);
        sw_we = 1'b1; sw_field = f; sw_ep = EPW'(ep); sw_val = v[0];
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic run_txn(input logic [3:0] tp, input logic [6:0] a, input int ep,
                           input logic [3:0] dp, input logic crc);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = tp; tok_addr = a; tok_ep = EPW'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        r_pre = int'(hs_valid || rx_commit || link_err);
        dat_valid = 1'b1; dat_pid = dp; crc_ok = crc;
        @(negedge clk);
        dat_valid = 1'b0; crc_ok = 1'b1;
        r_pid = hs_valid ? int'(hs_pid) : 0;
        r_commit = int'(rx_commit); r_setup = int'(rx_commit_setup);
        r_ep = int'(rx_commit_ep); r_err = int'(link_err);
        @(negedge clk);
        r_post = int'(hs_valid || rx_commit || link_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st, rxen, ave, iso, snak, tm, lvl, ep, tog;
        int rse, ase, ost, ist, e_pid, e_com, e_err, e_tog, e_rxen, dtog;
        logic [3:0] dp;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 toggle", int'(toggle), 0);
        chk("R1 out_stall", int'(out_stall), 0);
        chk("R1 in_stall", int'(in_stall), 0);
        chk("R1 rx_out_en", int'(rx_out_en), 0);
        chk("R1 outputs", int'(hs_valid || rx_commit || link_err), 0);

        // R11 software writes
        sw_wr(FLD_TOGGLE, 2, 1);
        chk("R11 toggle write 1", int'(toggle[2]), 1);
        sw_wr(FLD_ISTALL, 5, 1);
        chk("R11 in_stall write", int'(in_stall[5]), 1);
        sw_wr(FLD_ISTALL, 5, 0);
        sw_wr(FLD_TOGGLE, 2, 0);
        chk("R11 toggle write 0", int'(toggle[2]), 0);
        sw_wr(FLD_RXEN, 2, 1);
        run_txn(PID_OUT, ADDR, 2, PID_DATA0, 1'b1);
        chk("R11 DATA0 after reset", r_pid, int'(PID_ACK));
        chk("R11 commit", r_commit, 1);
        chk("R11 toggle flipped", int'(toggle[2]), 1);
        // R12 timing
        chk("R12 quiet before", r_pre, 0);
        chk("R12 quiet after", r_post, 0);

        // R2 ignored tokens
        run_txn(PID_OUT, ADDR ^ 7'h01, 2, PID_DATA1, 1'b1);
        chk("R2 addr mismatch", r_pid + r_commit + r_err, 0);
        chk("R2 addr mismatch toggle", int'(toggle[2]), 1);
        run_txn(PID_OUT, ADDR, 12, PID_DATA0, 1'b1);
        chk("R2 endpoint out of range", r_pid + r_commit + r_err, 0);
        ep_en[2] = 1'b0;
        run_txn(PID_OUT, ADDR, 2, PID_DATA1, 1'b1);
        chk("R2 disabled endpoint", r_pid + r_commit + r_err, 0);
        chk("R2 disabled toggle", int'(toggle[2]), 1);
        ep_en[2] = 1'b1;
        run_txn(4'b1001, ADDR, 2, PID_DATA1, 1'b1);
        chk("R2 non-OUT token", r_pid + r_commit + r_err, 0);
        @(negedge clk);
        dat_valid = 1'b1; dat_pid = PID_DATA1;
        @(negedge clk);
        dat_valid = 1'b0;
        chk("R2 stray data", int'(hs_valid || rx_commit), 0);

        // R10 bad CRC / bad data PID
        run_txn(PID_OUT, ADDR, 2, PID_DATA1, 1'b0);
        chk("R10 crc fail", r_pid + r_commit + r_err, 0);
        chk("R10 crc toggle", int'(toggle[2]), 1);
        run_txn(PID_OUT, ADDR, 2, 4'b0111, 1'b1);
        chk("R10 bad data pid", r_pid + r_commit + r_err, 0);

        // OUT sweep
        for (int idx = 0; idx < 320; idx++) begin
            st = idx & 1; rxen = (idx >> 1) & 1; ave = (idx >> 2) & 1;
            iso = (idx >> 3) & 1; snak = (idx >> 4) & 1; tm = (idx >> 5) & 1;
            lvl = idx / 64; ep = idx % NEP; tog = (idx / 3) & 1;
            iso_v = '0; iso_v[ep] = iso[0];
            snak_v = '0; snak_v[ep] = snak[0];
            av_out_empty = ave[0];
            rx_level = LVL_W'(lvl);
            sw_wr(FLD_TOGGLE, ep, tog);
            sw_wr(FLD_OSTALL, ep, st);
            sw_wr(FLD_RXEN, ep, rxen);
            dtog = (tm != 0) ? tog : 1 - tog;
            dp = (dtog != 0) ? PID_DATA1 : PID_DATA0;
            run_txn(PID_OUT, ADDR, ep, dp, 1'b1);
            e_com = 0; e_err = 0; e_tog = tog; e_rxen = rxen;
            if (st != 0) begin
                tag = "R3"; e_pid = (iso != 0) ? 0 : int'(PID_STALL);
            end else if (rxen == 0) begin
                tag = "R4"; e_pid = (iso != 0) ? 0 : int'(PID_NAK);
            end else if (ave != 0 || lvl >= RXD - 1) begin
                tag = "R5"; e_pid = (iso != 0) ? 0 : int'(PID_NAK);
            end else if (iso != 0) begin
                tag = "R8"; e_pid = 0; e_com = 1; e_rxen = (snak != 0) ? 0 : 1;
            end else if (tm == 0) begin
                tag = "R7"; e_pid = int'(PID_ACK); e_err = 1;
            end else begin
                tag = "R6"; e_pid = int'(PID_ACK); e_com = 1; e_tog = 1 - tog;
                e_rxen = (snak != 0) ? 0 : 1;
            end
            chk({tag, " handshake"}, r_pid, e_pid);
            chk({tag, " commit"}, r_commit, e_com);
            if (e_com != 0) chk({tag, " commit ep"}, r_ep, ep);
            chk({tag, " commit setup flag"}, r_setup, 0);
            chk({tag, " link err"}, r_err, e_err);
            chk({tag, " toggle"}, int'(toggle[ep]), e_tog);
            chk({tag, " rx enable"}, int'(rx_out_en[ep]), e_rxen);
            chk({tag, " out stall kept"}, int'(out_stall[ep]), st);
        end
        iso_v = '0; snak_v = '0; av_out_empty = 1'b0;

        // SETUP sweep
        for (int idx = 0; idx < 80; idx++) begin
            rse = idx & 1; ase = (idx >> 1) & 1; ost = (idx >> 2) & 1;
            ist = (idx >> 3) & 1; lvl = idx / 16; ep = idx % NEP;
            rse_v = '1; rse_v[ep] = rse[0];
            av_setup_empty = ase[0];
            rx_level = LVL_W'(lvl);
            sw_wr(FLD_TOGGLE, ep, 0);
            sw_wr(FLD_OSTALL, ep, ost);
            sw_wr(FLD_ISTALL, ep, ist);
            run_txn(PID_SETUP, ADDR, ep, PID_DATA0, 1'b1);
            tag = (lvl == RXD - 1) ? "R5 R9" : "R9";
            if (rse != 0 && ase == 0 && lvl < RXD) begin
                chk({tag, " setup ack"}, r_pid, int'(PID_ACK));
                chk({tag, " setup commit"}, r_commit + r_setup, 2);
                chk({tag, " setup ep"}, r_ep, ep);
                chk({tag, " stalls cleared"}, int'(out_stall[ep]) + int'(in_stall[ep]), 0);
                chk({tag, " toggle set"}, int'(toggle[ep]), 1);
            end else begin
                chk({tag, " setup dropped"}, r_pid + r_commit + r_setup, 0);
                chk({tag, " out stall kept"}, int'(out_stall[ep]), ost);
                chk({tag, " in stall kept"}, int'(in_stall[ep]), ist);
                chk({tag, " toggle kept"}, int'(toggle[ep]), 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule